// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits inside an SDRAM controller and owns the clock-enable (CKE) pin of one SDRAM device. It tracks the power mode the device is in, decides when CKE falls and rises, and tells the command scheduler on which edges an ordinary command may be issued. The mode follows from three things seen at each clock edge: the CKE level the device saw at the previous edge, the CKE level at this edge, and the command placed on the bus for this edge.

The scheduler raises a request to suspend the clock, to power down, to enter self refresh or to wake up. It also reports whether all banks are idle and whether a read or write burst is running. The block drops CKE when a request is acceptable. On the falling edge, the state of the device and the command on the bus choose among clock suspend, power-down and self refresh. On wake it raises CKE again and returns to normal operation. After self refresh it holds off ordinary commands for a programmable recovery window, which also requires at least two NOPs. A combination of CKE history, mode and command that the rules do not allow raises a sticky error flag and leaves the mode unchanged.

Top module: `cke_pwr_seq`

## Requirements
- R1: While reset is low and on the first edge after it, CKE is high, mode is run (0), the command-allowed strobe is high and the error flag is low.
- R2: In run mode with CKE high and a burst in progress, a suspend or power-down request drives CKE low at the next edge. On the edge after that the mode becomes clock suspend (1), whatever the command.
- R3: In run mode with all banks idle and no burst, a power-down request drives CKE low. If the command on the next edge is NOP (code 0) or INHIBIT (code 1), the mode becomes power-down (2).
- R4: Under the same conditions, a self-refresh or power-down request followed by AUTO REFRESH (code 2) on the falling edge gives mode self refresh (3).
- R5: A power-down or self-refresh request while banks are not idle and no burst is running leaves CKE high and the mode at run.
- R6: In suspend, power-down or self refresh with CKE low on both edges, the command code (any of 0 to 7) changes neither the mode nor the error flag.
- R7: A wake request in suspend or power-down raises CKE at the next edge. The edge after that returns the mode to run and the strobe goes high. The power-down exit edge must carry NOP or INHIBIT.
- R8: Leaving self refresh with NOP or INHIBIT on the exit edge gives the recovery mode (4). The strobe stays low until SREF_EXIT_CYCLES recovery edges have passed and at least two NOPs have been counted on them. Then the mode returns to run.
- R9: An illegal combination sets the error flag, which stays set until reset, and leaves the mode unchanged. Examples are ACTIVE (code 3) on the falling edge with banks idle and no burst, and a command other than NOP or INHIBIT on a power-down exit or recovery edge. After an illegal falling edge, CKE returns high.
- R10: The command-allowed strobe is high exactly when the mode is run and CKE is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_suspend_i | input | 1 | Request to freeze the clock during a burst |
| req_pdown_i | input | 1 | Request to enter power-down (or suspend during a burst) |
| req_sref_i | input | 1 | Request to enter self refresh |
| req_wake_i | input | 1 | Request to leave the current low-power mode |
| banks_idle_i | input | 1 | All banks are precharged |
| burst_active_i | input | 1 | A read or write burst is in progress |
| cmd_i | input | 3 | Command on the bus this edge: 0 NOP, 1 INHIBIT, 2 AUTO REFRESH, 3 ACTIVE, 4 READ, 5 WRITE, 6 PRECHARGE, 7 other |
| cke_o | output | 1 | Clock-enable level driven to the device |
| cmd_ok_o | output | 1 | Any command may be issued on the next edge |
| mode_o | output | 3 | 0 run, 1 suspend, 2 power-down, 3 self refresh, 4 self-refresh recovery |
| err_o | output | 1 | Sticky illegal-sequence flag |

## Verification
The hardest case to reach is the two-NOP rule inside self-refresh recovery. The device must first pass through a legal entry with AUTO REFRESH on the falling edge and then a legal exit. After that, the recovery edges must carry INHIBIT for longer than the cycle window before any NOP is given. Directed sequences build that path step by step and check the edge on which the strobe returns. Seeded random requests and commands then visit the other transitions, including illegal ones, against a cycle model in the bench.

// File: rtl/cke_seq_pkg.sv
// Shared types for the clock-enable power-state sequencer.
// Assumes a 3-bit decoded command code supplied by the scheduler.
package cke_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_INHIBIT = 3'd1,
        CMD_AREF    = 3'd2,
        CMD_ACT     = 3'd3,
        CMD_READ    = 3'd4,
        CMD_WRITE   = 3'd5,
        CMD_PRE     = 3'd6,
        CMD_OTHER   = 3'd7
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_SUSPEND = 3'd1,
        PM_PDOWN   = 3'd2,
        PM_SREF    = 3'd3,
        PM_RECOVER = 3'd4
    } pwr_mode_e;

    // True for commands that leave the device untouched
    function automatic logic cmd_is_quiet(input logic [2:0] c);
        return (c == CMD_NOP) || (c == CMD_INHIBIT);
    endfunction

    // True for modes in which CKE is parked low
    function automatic logic mode_is_low_power(input pwr_mode_e m);
        return (m == PM_SUSPEND) || (m == PM_PDOWN) || (m == PM_SREF);
    endfunction

endpackage

// File: rtl/sref_exit_timer.sv
// Recovery timer for leaving self refresh.
// Counts legal recovery edges and NOPs. Ready reports, for the
// current edge, that the window has run out and that two NOPs will
// have been seen once this edge's command is counted.
// Assumes start and step are never high together.
module sref_exit_timer #(
    parameter int EXIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic nop_i,
    output logic ready_o
);
    localparam int CW    = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;
    localparam int LIMIT = EXIT_CYCLES - 1;

    logic [CW-1:0] edge_cnt;
    logic [1:0]    nop_cnt;
    logic [2:0]    nop_total;

    // Purpose: NOPs seen so far plus the one on this edge
    always_comb nop_total = {1'b0, nop_cnt} + {2'b00, nop_i};

    // Purpose: edge counter and saturating NOP counter
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            edge_cnt <= '0;
            nop_cnt  <= '0;
        end else if (step_i) begin
            if (edge_cnt < CW'(LIMIT)) edge_cnt <= edge_cnt + 1'b1;
            if (nop_total >= 3'd2) nop_cnt <= 2'd2;
            else                   nop_cnt <= nop_total[1:0];
        end
    end

    // Purpose: both recovery conditions met on this edge
    always_comb ready_o = (edge_cnt >= CW'(LIMIT)) && (nop_total >= 3'd2);

endmodule

// File: rtl/cke_mode_fsm.sv
// Next-mode table for the power-state sequencer.
// Takes the CKE level of the previous and current edge, the command
// and the bank state, and returns the next mode or an illegal flag.
// Assumes the caller holds the mode when illegal is raised.
module cke_mode_fsm
    import cke_seq_pkg::*;
(
    input  pwr_mode_e  mode_i,
    input  logic       cke_prev_i,
    input  logic       cke_now_i,
    input  logic [2:0] cmd_i,
    input  logic       burst_i,
    input  logic       idle_i,
    input  logic       rec_ready_i,
    output pwr_mode_e  mode_next_o,
    output logic       illegal_o,
    output logic       rec_start_o,
    output logic       rec_step_o
);
    logic quiet;

    // Purpose: classify the command
    always_comb quiet = cmd_is_quiet(cmd_i);

    // Purpose: transition table keyed on mode and CKE history
    always_comb begin
        mode_next_o = mode_i;
        illegal_o   = 1'b0;
        rec_start_o = 1'b0;
        rec_step_o  = 1'b0;
        case (mode_i)
            PM_RUN: begin
                if (!cke_now_i) begin
                    if (!cke_prev_i)                     illegal_o   = 1'b1;
                    else if (burst_i)                    mode_next_o = PM_SUSPEND;
                    else if (idle_i && quiet)            mode_next_o = PM_PDOWN;
                    else if (idle_i && cmd_i == CMD_AREF) mode_next_o = PM_SREF;
                    else                                 illegal_o   = 1'b1;
                end
            end
            PM_SUSPEND, PM_PDOWN, PM_SREF: begin
                if (cke_prev_i) begin
                    illegal_o = 1'b1;
                end else if (cke_now_i) begin
                    if (mode_i == PM_SUSPEND)   mode_next_o = PM_RUN;
                    else if (!quiet)            illegal_o   = 1'b1;
                    else if (mode_i == PM_PDOWN) mode_next_o = PM_RUN;
                    else begin
                        mode_next_o = PM_RECOVER;
                        rec_start_o = 1'b1;
                    end
                end
            end
            PM_RECOVER: begin
                if (!cke_now_i || !cke_prev_i || !quiet) begin
                    illegal_o = 1'b1;
                end else begin
                    rec_step_o = 1'b1;
                    if (rec_ready_i) mode_next_o = PM_RUN;
                end
            end
            default: illegal_o = 1'b1;
        endcase
        if (illegal_o) mode_next_o = mode_i;
    end

endmodule

// File: rtl/cke_drive_arb.sv
// Decides the CKE level for the next edge.
// Lowers CKE for an acceptable entry request in run mode. Raises it on
// wake in a low-power mode, or when a falling edge failed to enter one.
module cke_drive_arb
    import cke_seq_pkg::*;
(
    input  pwr_mode_e mode_i,
    input  pwr_mode_e mode_next_i,
    input  logic      cke_now_i,
    input  logic      req_suspend_i,
    input  logic      req_pdown_i,
    input  logic      req_sref_i,
    input  logic      req_wake_i,
    input  logic      burst_i,
    input  logic      idle_i,
    output logic      cke_next_o
);
    logic enter_ok;

    // Purpose: entry request acceptable under the bank and burst state
    always_comb enter_ok = (mode_i == PM_RUN) &&
        ((burst_i && (req_suspend_i || req_pdown_i)) ||
         (!burst_i && idle_i && (req_pdown_i || req_sref_i)));

    // Purpose: next CKE level
    always_comb begin
        if (cke_now_i) cke_next_o = !enter_ok;
        else           cke_next_o = (mode_next_i == PM_RUN) ||
                                    (mode_is_low_power(mode_i) && req_wake_i);
    end

endmodule

// File: rtl/cke_pwr_seq.sv
// Clock-enable power-state sequencer, top level.
// Holds CKE, its previous level, the mode and the sticky error.
// Assumes requests are levels sampled every edge. The command on
// cmd_i is the one the device registers on the same edge.
module cke_pwr_seq
    import cke_seq_pkg::*;
#(
    parameter int SREF_EXIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_suspend_i,
    input  logic       req_pdown_i,
    input  logic       req_sref_i,
    input  logic       req_wake_i,
    input  logic       banks_idle_i,
    input  logic       burst_active_i,
    input  logic [2:0] cmd_i,
    output logic       cke_o,
    output logic       cmd_ok_o,
    output logic [2:0] mode_o,
    output logic       err_o
);
    logic      cke_q, cke_prev_q, err_q, cke_next;
    logic      illegal, rec_start, rec_step, rec_ready;
    pwr_mode_e mode_q, mode_next;

    cke_mode_fsm i_fsm (
        .mode_i      (mode_q),
        .cke_prev_i  (cke_prev_q),
        .cke_now_i   (cke_q),
        .cmd_i       (cmd_i),
        .burst_i     (burst_active_i),
        .idle_i      (banks_idle_i),
        .rec_ready_i (rec_ready),
        .mode_next_o (mode_next),
        .illegal_o   (illegal),
        .rec_start_o (rec_start),
        .rec_step_o  (rec_step)
    );

    sref_exit_timer #(.EXIT_CYCLES(SREF_EXIT_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rec_start),
        .step_i  (rec_step),
        .nop_i   (cmd_i == CMD_NOP),
        .ready_o (rec_ready)
    );

    cke_drive_arb i_arb (
        .mode_i        (mode_q),
        .mode_next_i   (mode_next),
        .cke_now_i     (cke_q),
        .req_suspend_i (req_suspend_i),
        .req_pdown_i   (req_pdown_i),
        .req_sref_i    (req_sref_i),
        .req_wake_i    (req_wake_i),
        .burst_i       (burst_active_i),
        .idle_i        (banks_idle_i),
        .cke_next_o    (cke_next)
    );

    // Purpose: state registers for CKE history, mode and error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q      <= 1'b1;
            cke_prev_q <= 1'b1;
            mode_q     <= PM_RUN;
            err_q      <= 1'b0;
        end else begin
            cke_q      <= cke_next;
            cke_prev_q <= cke_q;
            mode_q     <= mode_next;
            err_q      <= err_q || illegal;
        end
    end

    // Purpose: drive outputs from registered state
    always_comb begin
        cke_o    = cke_q;
        mode_o   = mode_q;
        err_o    = err_q;
        cmd_ok_o = (mode_q == PM_RUN) && cke_q;
    end

endmodule

// File: rtl/cke_pwr_seq_chk.sv
// Property checker for the power-state sequencer, bound to the top.
// Observes ports only. Mode codes: 0 run, 1 suspend, 2 power-down,
// 3 self refresh, 4 recovery.
module cke_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       burst_active_i,
    input logic       cke_o,
    input logic       cmd_ok_o,
    input logic [2:0] mode_o,
    input logic       err_o
);
    localparam logic [2:0] M_RUN = 3'd0, M_SUS = 3'd1, M_PD = 3'd2,
                           M_SR = 3'd3, M_REC = 3'd4;

    // R1: reset leaves run mode with CKE high and no error
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cke_o && mode_o == M_RUN && !err_o));

    // R2: first low-CKE cycle in run mode during a burst enters suspend
    assert_suspend_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_RUN && !cke_o && burst_active_i) |=> (mode_o == M_SUS));

    // R6: parked low-power mode with CKE low twice holds its mode
    assert_lp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == M_SUS || mode_o == M_PD || mode_o == M_SR) && !cke_o && !$past(cke_o))
        |=> $stable(mode_o));

    // R7: suspend with CKE raised returns to run
    assert_suspend_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SUS && cke_o) |=> (mode_o == M_RUN));

    // R8: self refresh with CKE raised goes to recovery unless flagged
    assert_sref_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SR && cke_o) |=> (mode_o == M_REC || (mode_o == M_SR && err_o)));

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9: a newly flagged error leaves the mode alone
    assert_err_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $stable(mode_o));

    // R10: no command strobe while CKE is low or during recovery
    assert_strobe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o || mode_o == M_REC) |-> !cmd_ok_o);

endmodule

bind cke_pwr_seq cke_pwr_seq_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .burst_active_i (burst_active_i),
    .cke_o          (cke_o),
    .cmd_ok_o       (cmd_ok_o),
    .mode_o         (mode_o),
    .err_o          (err_o)
);

// File: tb/test_cke_pwr_seq.sv
`timescale 1ns/1ps
module test_cke_pwr_seq;
    localparam int XSR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_suspend = 0, req_pdown = 0, req_sref = 0, req_wake = 0;
    logic       idle = 0, burst = 0;
    logic [2:0] cmd = 3'd0;
    logic       cke, cmd_ok, err;
    logic [2:0] mode;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cke_pwr_seq #(.SREF_EXIT_CYCLES(XSR)) i_cke_pwr_seq (
        .clk(clk), .rst_n(rst_n),
        .req_suspend_i(req_suspend), .req_pdown_i(req_pdown),
        .req_sref_i(req_sref), .req_wake_i(req_wake),
        .banks_idle_i(idle), .burst_active_i(burst), .cmd_i(cmd),
        .cke_o(cke), .cmd_ok_o(cmd_ok), .mode_o(mode), .err_o(err)
    );

    // Cycle model of the requirements
    logic e_cke, e_prev, e_err;
    int   e_mode, e_cnt, e_nops;
    int   nm;
    logic bad, quiet, enter, step, start;

    function automatic logic lowp(input int m);
        return (m >= 1) && (m <= 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_cke <= 1; e_prev <= 1; e_mode <= 0; e_err <= 0; e_cnt <= 0; e_nops <= 0;
        end else begin
            quiet = (cmd <= 3'd1);
            nm = e_mode; bad = 0; step = 0; start = 0;
            if (e_mode == 0) begin
                if (!e_cke) begin
                    if (!e_prev) bad = 1;
                    else if (burst) nm = 1;
                    else if (idle && quiet) nm = 2;
                    else if (idle && cmd == 3'd2) nm = 3;
                    else bad = 1;
                end
            end else if (lowp(e_mode)) begin
                if (e_prev) bad = 1;
                else if (e_cke) begin
                    if (e_mode == 1) nm = 0;
                    else if (!quiet) bad = 1;
                    else if (e_mode == 2) nm = 0;
                    else begin nm = 4; start = 1; end
                end
            end else begin
                if (!e_cke || !e_prev || !quiet) bad = 1;
                else begin
                    step = 1;
                    if (e_cnt >= XSR - 1 && e_nops + (cmd == 3'd0 ? 1 : 0) >= 2) nm = 0;
                end
            end
            if (bad) nm = e_mode;
            enter = (e_mode == 0) && ((burst && (req_suspend || req_pdown)) ||
                                      (!burst && idle && (req_pdown || req_sref)));
            if (e_cke) e_cke <= !enter;
            else       e_cke <= (nm == 0) || (lowp(e_mode) && req_wake);
            e_prev <= e_cke;
            e_mode <= nm;
            e_err  <= e_err || bad;
            if (start) begin e_cnt <= 0; e_nops <= 0; end
            else if (step) begin
                if (e_cnt < XSR - 1) e_cnt <= e_cnt + 1;
                e_nops <= (e_nops + (cmd == 3'd0 ? 1 : 0) >= 2) ? 2 : e_nops + (cmd == 3'd0 ? 1 : 0);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 cke", int'(cke), int'(e_cke));
            chk("R6 mode", int'(mode), e_mode);
            chk("R9 err", int'(err), int'(e_err));
            chk("R10 strobe", int'(cmd_ok), (e_mode == 0 && e_cke) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; req_suspend = 0; req_pdown = 0; req_sref = 0; req_wake = 0;
        idle = 0; burst = 0; cmd = 3'd0;
        tick(); tick();
        rst_n = 1;
    endtask

    // Enter self refresh from run with banks idle, then leave it
    task automatic sref_enter_exit();
        idle = 1; cmd = 3'd0; req_sref = 1; tick(); req_sref = 0;
        cmd = 3'd2; tick();
        chk("R4 sref mode", int'(mode), 3);
        cmd = 3'd0; req_wake = 1; tick(); req_wake = 0;
        tick();
        chk("R8 recover mode", int'(mode), 4);
        chk("R8 strobe low", int'(cmd_ok), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        chk("R1 cke", int'(cke), 1);
        chk("R1 mode", int'(mode), 0);
        chk("R1 strobe", int'(cmd_ok), 1);
        chk("R1 err", int'(err), 0);

        // R5: requests without idle banks or burst are ignored
        req_pdown = 1; tick(); req_pdown = 0;
        chk("R5 cke after pdown req", int'(cke), 1);
        req_sref = 1; tick(); req_sref = 0;
        chk("R5 cke after sref req", int'(cke), 1);
        tick();
        chk("R5 mode", int'(mode), 0);

        // R2 suspend entry, R6 don't-care commands, R7 exit
        burst = 1; req_suspend = 1; tick(); req_suspend = 0;
        chk("R2 cke low", int'(cke), 0);
        chk("R10 strobe low", int'(cmd_ok), 0);
        cmd = 3'd5; tick();
        chk("R2 suspend mode", int'(mode), 1);
        cmd = 3'd3; tick(); cmd = 3'd7; tick();
        chk("R6 suspend held", int'(mode), 1);
        chk("R6 no error", int'(err), 0);
        cmd = 3'd0; req_wake = 1; tick(); req_wake = 0;
        chk("R7 cke raised", int'(cke), 1);
        chk("R7 still suspend", int'(mode), 1);
        tick();
        chk("R7 run again", int'(mode), 0);
        chk("R7 strobe", int'(cmd_ok), 1);
        burst = 0;

        // R3 power-down with INHIBIT on falling edge
        idle = 1; req_pdown = 1; tick(); req_pdown = 0;
        cmd = 3'd1; tick();
        chk("R3 pdown mode", int'(mode), 2);
        cmd = 3'd6; tick();
        chk("R6 pdown held", int'(mode), 2);
        cmd = 3'd0; req_wake = 1; tick(); req_wake = 0; tick();
        chk("R7 pdown exit", int'(mode), 0);
        chk("R7 no error", int'(err), 0);

        // R8 recovery window with NOPs
        sref_enter_exit();
        for (int k = 0; k < XSR - 1; k++) begin
            tick();
            chk("R8 window strobe", int'(cmd_ok), 0);
        end
        tick();
        chk("R8 window end mode", int'(mode), 0);
        chk("R8 window end strobe", int'(cmd_ok), 1);

        // R8 two-NOP minimum after window ran out on INHIBIT
        sref_enter_exit();
        cmd = 3'd1;
        repeat (XSR + 2) tick();
        chk("R8 inhibit only", int'(mode), 4);
        cmd = 3'd0; tick();
        chk("R8 one nop", int'(mode), 4);
        tick();
        chk("R8 two nops", int'(mode), 0);
        chk("R8 no error", int'(err), 0);

        // R9 illegal falling edge
        req_pdown = 1; cmd = 3'd0; tick(); req_pdown = 0;
        cmd = 3'd3; tick();
        chk("R9 err set", int'(err), 1);
        chk("R9 mode kept", int'(mode), 0);
        chk("R9 cke back high", int'(cke), 1);
        cmd = 3'd0; repeat (3) tick();
        chk("R9 err sticky", int'(err), 1);

        // R9 power-down exit with READ
        do_reset();
        idle = 1; req_pdown = 1; tick(); req_pdown = 0; tick();
        req_wake = 1; tick(); req_wake = 0;
        cmd = 3'd4; tick();
        chk("R9 bad exit err", int'(err), 1);
        chk("R9 bad exit mode", int'(mode), 2);

        // Seeded random episodes, checked by the cycle model
        for (int ep = 0; ep < 24; ep++) begin
            do_reset();
            for (int c = 0; c < 250; c++) begin
                int r;
                req_suspend = ($urandom_range(0, 9) == 0);
                req_pdown   = ($urandom_range(0, 7) == 0);
                req_sref    = ($urandom_range(0, 7) == 0);
                req_wake    = ($urandom_range(0, 4) == 0);
                burst       = ($urandom_range(0, 9) < 3);
                idle        = ($urandom_range(0, 9) < 7);
                r = $urandom_range(0, 99);
                if (r < 45)      cmd = 3'd0;
                else if (r < 62) cmd = 3'd1;
                else if (r < 80) cmd = 3'd2;
                else             cmd = 3'($urandom_range(0, 7));
                tick();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule